// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation at a time as a fixed read-then-write sequence on a single memory port. A request supplies a 5-bit operation code, a 3-bit size code, a byte address and a source operand. The unit reads the old memory value and combines it with the operand in its own arithmetic/logic stage. It writes the combined value back to the same address and returns the old value, sign-extended to the register width, for the destination register.

The unit checks the request before it touches memory. An unknown operation code or an unsupported size is flagged as an illegal instruction. An address that is not aligned to the access size is flagged as misaligned. Neither case starts a memory access. An error reported by the memory on either access ends the operation with an access fault, and the faulting address is reported. The port is held from the start of the read until the write completes, so no other requester can slip an access in between.

The memory port carries data right-aligned. A word access uses bits [31:0] of the read and write data, and the memory side selects the byte lanes.

Top module: `amo_rmw_unit`

## Requirements
- R1: Operation codes are 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. Size code 010 selects word and 011 selects doubleword; doubleword is legal only when XLEN is 64. Any other operation or size completes with `done_illegal`, with no memory access and no register write.
- R2: The value written is the operand for swap, and operand + old, operand ^ old, operand & old and operand | old for add, xor, and and or.
- R3: Signed min and max select between operand and old value by two's-complement comparison.
- R4: Unsigned min and max compare as unsigned. For word accesses, both values are zero-extended from bit 31 for unsigned min and max, and sign-extended for every other operation, before the result is formed.
- R5: A word access drives `mem_dword` low and writes only bits [31:0] of the result, with `mem_wdata[XLEN-1:32]` zero. Bits [XLEN-1:32] of the read data are ignored.
- R6: On success `done_rd_we` is high and `done_rd_data` holds the old value, sign-extended from the access width, for every operation.
- R7: A word with address bits [1:0] not 00, or a doubleword with bits [2:0] not 000, completes with `done_misaligned`, with no memory access and no register write.
- R8: A read that returns `mem_err` ends the operation with `done_fault`, with no write access and no register write, and `done_fault_addr` holds the request address.
- R9: A write that returns `mem_err` ends with `done_fault` and no register write.
- R10: A legal aligned request issues exactly one read and then exactly one write, both to the request address. `mem_lock` is high whenever `mem_req` is high, from the read through the write.
- R11: After reset `req_ready` is high and `mem_req` and `done_valid` are low. Each accepted request produces exactly one single-cycle `done_valid` pulse, and `req_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Unit idle and able to accept |
| req_funct5 | input | 5 | Operation code |
| req_size | input | 3 | Size code (010 word, 011 doubleword) |
| req_addr | input | XLEN | Byte address |
| req_operand | input | XLEN | Source operand |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_dword | output | 1 | 1 for doubleword, 0 for word |
| mem_lock | output | 1 | Port claimed for the atomic sequence |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Right-aligned write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access error, valid with `mem_ack` |
| mem_rdata | input | XLEN | Right-aligned read data, valid with `mem_ack` |
| done_valid | output | 1 | Completion pulse |
| done_rd_we | output | 1 | Destination register write enable |
| done_rd_data | output | XLEN | Sign-extended old value |
| done_fault | output | 1 | Access fault on read or write |
| done_illegal | output | 1 | Illegal operation or size |
| done_misaligned | output | 1 | Misaligned address |
| done_fault_addr | output | XLEN | Address of the faulting or misaligned request |

## Verification
The bench runs every operation at both widths against a memory model. It chooses values that tell one operation from another: negative and positive values for signed against unsigned order, and carries out of bit 31 for word truncation. It also uses a memory model that returns junk above bit 31 on word reads, so that zero-extension is distinguished from sign-extension and the upper half is shown to be ignored. Illegal, misaligned and fault-region addresses are mixed with good requests. Per-transaction read and write counts, together with the final memory contents, show whether each error stopped the sequence at the right step.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_DONE
    } seq_state_e;

    localparam logic [2:0] SZ_WORD  = 3'b010;
    localparam logic [2:0] SZ_DWORD = 3'b011;

    typedef struct packed {
        amo_op_e op;
        logic    dword;
        logic    illegal;
        logic    misaligned;
    } amo_decode_t;

    function automatic logic op_is_unsigned(amo_op_e op);
        return (op == OP_MINU) || (op == OP_MAXU);
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]  funct5,
    input  logic [2:0]  size,
    input  logic [2:0]  addr_lo,
    output amo_decode_t dec
);
    localparam bit DWORD_OK = (XLEN >= 64);

    logic    bad_op;
    logic    bad_size;
    amo_op_e op;

    always_comb begin
        bad_op = 1'b0;
        op     = OP_SWAP;
        unique case (funct5)
            5'b00001: op = OP_SWAP;
            5'b00000: op = OP_ADD;
            5'b00100: op = OP_XOR;
            5'b01100: op = OP_AND;
            5'b01000: op = OP_OR;
            5'b10000: op = OP_MIN;
            5'b10100: op = OP_MAX;
            5'b11000: op = OP_MINU;
            5'b11100: op = OP_MAXU;
            default:  bad_op = 1'b1;
        endcase
    end

    always_comb begin
        bad_size = 1'b1;
        if (size == SZ_WORD)                 bad_size = 1'b0;
        else if (size == SZ_DWORD && DWORD_OK) bad_size = 1'b0;
    end

    always_comb begin
        dec.op         = op;
        dec.dword      = (size == SZ_DWORD);
        dec.illegal    = bad_op | bad_size;
        dec.misaligned = !(bad_op | bad_size) &&
                         ((size == SZ_DWORD) ? (addr_lo != 3'b000)
                                             : (addr_lo[1:0] != 2'b00));
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_op_e          op,
    input  logic             dword,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  operand,
    output logic [XLEN-1:0]  new_val,
    output logic [XLEN-1:0]  rd_val
);
    localparam logic [XLEN-1:0] LO_MASK = XLEN'(64'h0000_0000_FFFF_FFFF);

    function automatic logic [XLEN-1:0] widen(logic [XLEN-1:0] v, logic dw, logic uns);
        logic [XLEN-1:0] lo;
        lo = v & LO_MASK;
        if (dw)  return v;
        if (uns) return lo;
        return lo | (v[31] ? ~LO_MASK : '0);
    endfunction

    logic            uns;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] res;
    logic            s_lt;
    logic            u_lt;

    always_comb begin
        uns  = op_is_unsigned(op);
        a    = widen(operand, dword, uns);
        b    = widen(old_val, dword, uns);
        s_lt = $signed(a) < $signed(b);
        u_lt = a < b;
        unique case (op)
            OP_SWAP: res = a;
            OP_ADD:  res = a + b;
            OP_XOR:  res = a ^ b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_MIN:  res = s_lt ? a : b;
            OP_MAX:  res = s_lt ? b : a;
            OP_MINU: res = u_lt ? a : b;
            OP_MAXU: res = u_lt ? b : a;
            default: res = a;
        endcase
        new_val = dword ? res : (res & LO_MASK);
        rd_val  = widen(old_val, dword, 1'b0);
    end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  amo_decode_t      dec,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [XLEN-1:0]  req_operand,
    output logic             idle,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_dword,
    output logic             mem_lock,
    output logic [XLEN-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [XLEN-1:0]  mem_rdata,
    output amo_op_e          op_q,
    output logic [XLEN-1:0]  operand_q,
    output logic [XLEN-1:0]  old_q,
    output logic             done_valid,
    output logic             done_rd_we,
    output logic             done_fault,
    output logic             done_illegal,
    output logic             done_misaligned
);
    seq_state_e state, state_nx;
    logic       fault_q, illegal_q, misal_q, dword_q, lock_q;
    logic [XLEN-1:0] addr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)
                          state_nx = (dec.illegal || dec.misaligned) ? ST_DONE : ST_READ;
            ST_READ:  if (mem_ack) state_nx = mem_err ? ST_DONE : ST_WRITE;
            ST_WRITE: if (mem_ack) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fault_q   <= 1'b0;
            illegal_q <= 1'b0;
            misal_q   <= 1'b0;
            dword_q   <= 1'b0;
            lock_q    <= 1'b0;
            addr_q    <= '0;
            operand_q <= '0;
            old_q     <= '0;
            op_q      <= OP_SWAP;
        end else begin
            state  <= state_nx;
            lock_q <= (state_nx == ST_READ) || (state_nx == ST_WRITE);
            if (state == ST_IDLE && start) begin
                fault_q   <= 1'b0;
                illegal_q <= dec.illegal;
                misal_q   <= dec.misaligned;
                dword_q   <= dec.dword;
                op_q      <= dec.op;
                addr_q    <= req_addr;
                operand_q <= req_operand;
            end
            if (state == ST_READ && mem_ack) begin
                if (mem_err) fault_q <= 1'b1;
                else         old_q   <= mem_rdata;
            end
            if (state == ST_WRITE && mem_ack && mem_err) fault_q <= 1'b1;
        end
    end

    assign idle            = (state == ST_IDLE);
    assign mem_req         = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we          = (state == ST_WRITE);
    assign mem_dword       = dword_q;
    assign mem_lock        = lock_q;
    assign mem_addr        = addr_q;
    assign done_valid      = (state == ST_DONE);
    assign done_fault      = fault_q;
    assign done_illegal    = illegal_q;
    assign done_misaligned = misal_q;
    assign done_rd_we      = (state == ST_DONE) && !fault_q && !illegal_q && !misal_q;

    a_r10_lock_held: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);
    a_r10_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));
    a_r8_no_write_after_bad_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack && mem_err) |=> !mem_req);
    a_r1_illegal_no_access: assert property (@(posedge clk) disable iff (rst)
        (idle && start && dec.illegal) |=> (!mem_req && done_valid));
    a_r7_misaligned_no_access: assert property (@(posedge clk) disable iff (rst)
        (idle && start && dec.misaligned) |=> (!mem_req && done_valid));
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [4:0]       req_funct5,
    input  logic [2:0]       req_size,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [XLEN-1:0]  req_operand,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_dword,
    output logic             mem_lock,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             done_valid,
    output logic             done_rd_we,
    output logic [XLEN-1:0]  done_rd_data,
    output logic             done_fault,
    output logic             done_illegal,
    output logic             done_misaligned,
    output logic [XLEN-1:0]  done_fault_addr
);
    amo_decode_t     dec;
    amo_op_e         op_q;
    logic [XLEN-1:0] operand_q;
    logic [XLEN-1:0] old_q;
    logic [XLEN-1:0] rd_val;
    logic            idle;
    logic            start;

    assign req_ready = idle;
    assign start     = req_valid && idle;

    amo_decode #(.XLEN(XLEN)) u_dec (
        .funct5  (req_funct5),
        .size    (req_size),
        .addr_lo (req_addr[2:0]),
        .dec     (dec)
    );

    amo_seq #(.XLEN(XLEN)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .dec             (dec),
        .req_addr        (req_addr),
        .req_operand     (req_operand),
        .idle            (idle),
        .mem_req         (mem_req),
        .mem_we          (mem_we),
        .mem_dword       (mem_dword),
        .mem_lock        (mem_lock),
        .mem_addr        (mem_addr),
        .mem_ack         (mem_ack),
        .mem_err         (mem_err),
        .mem_rdata       (mem_rdata),
        .op_q            (op_q),
        .operand_q       (operand_q),
        .old_q           (old_q),
        .done_valid      (done_valid),
        .done_rd_we      (done_rd_we),
        .done_fault      (done_fault),
        .done_illegal    (done_illegal),
        .done_misaligned (done_misaligned)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .dword   (mem_dword),
        .old_val (old_q),
        .operand (operand_q),
        .new_val (mem_wdata),
        .rd_val  (rd_val)
    );

    assign done_rd_data    = done_rd_we ? rd_val : '0;
    assign done_fault_addr = mem_addr;

    generate
        if (XLEN > 32) begin : g_upper_chk
            a_r5_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
                (mem_req && mem_we && !mem_dword) |-> (mem_wdata[XLEN-1:32] == '0));
        end
    endgenerate

endmodule

// File: tb/sim_amo_rmw_unit.sv
`timescale 1ns/1ps
module sim_amo_rmw_unit;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [4:0]      req_funct5 = '0;
    logic [2:0]      req_size = '0;
    logic [63:0]     req_addr = '0;
    logic [63:0]     req_operand = '0;
    logic            mem_req, mem_we, mem_dword, mem_lock;
    logic [63:0]     mem_addr, mem_wdata;
    logic            mem_ack, mem_err;
    logic [63:0]     mem_rdata;
    logic            done_valid, done_rd_we, done_fault, done_illegal, done_misaligned;
    logic [63:0]     done_rd_data, done_fault_addr;

    amo_rmw_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_funct5(req_funct5), .req_size(req_size), .req_addr(req_addr),
        .req_operand(req_operand), .mem_req(mem_req), .mem_we(mem_we),
        .mem_dword(mem_dword), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .done_valid(done_valid), .done_rd_we(done_rd_we),
        .done_rd_data(done_rd_data), .done_fault(done_fault),
        .done_illegal(done_illegal), .done_misaligned(done_misaligned),
        .done_fault_addr(done_fault_addr)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: 16 doublewords indexed by addr[6:3]; addr[11:8]==F read error, ==E write error
    logic [63:0] mem [16];
    int n_reads = 0, n_writes = 0, lock_bad = 0;
    logic [63:0] rd_addr_seen, wr_addr_seen;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (!mem_we) begin
                    n_reads <= n_reads + 1;
                    rd_addr_seen <= mem_addr;
                    mem_err <= (mem_addr[11:8] == 4'hF);
                    if (mem_dword) mem_rdata <= mem[mem_addr[6:3]];
                    else mem_rdata <= {32'hDEAD_BEEF,
                        mem_addr[2] ? mem[mem_addr[6:3]][63:32] : mem[mem_addr[6:3]][31:0]};
                end else begin
                    n_writes <= n_writes + 1;
                    wr_addr_seen <= mem_addr;
                    mem_err <= (mem_addr[11:8] == 4'hE);
                    if (mem_addr[11:8] != 4'hE) begin
                        if (mem_dword) mem[mem_addr[6:3]] <= mem_wdata;
                        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
                        else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
                    end
                end
            end
        end
    end

    always @(negedge clk) if (!rst && mem_req && !mem_lock) lock_bad++;

    typedef struct {
        logic        rd_we;
        logic [63:0] rd_data;
        logic [2:0]  flags;     // {fault, illegal, misaligned}
        int          reads;
        int          writes;
        int          idx;
        logic [63:0] mem_exp;
        logic [63:0] addr;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    done_seen = 0;

    function automatic logic [63:0] sx32(logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] ref_result(logic [4:0] f5, logic dw, logic [63:0] o, logic [63:0] x);
        logic uns;
        logic [63:0] p, q;
        uns = (f5 == 5'b11000) || (f5 == 5'b11100);
        p = dw ? x : (uns ? {32'b0, x[31:0]} : sx32(x[31:0]));
        q = dw ? o : (uns ? {32'b0, o[31:0]} : sx32(o[31:0]));
        case (f5)
            5'b00001: return p;
            5'b00000: return p + q;
            5'b00100: return p ^ q;
            5'b01100: return p & q;
            5'b01000: return p | q;
            5'b10000: return ($signed(p) <= $signed(q)) ? p : q;
            5'b10100: return ($signed(p) >= $signed(q)) ? p : q;
            5'b11000: return (p <= q) ? p : q;
            default:  return (p >= q) ? p : q;
        endcase
    endfunction

    task automatic do_amo(input string tag, input logic [4:0] f5, input logic [2:0] sz,
                          input logic [63:0] addr, input logic [63:0] opd);
        exp_t e;
        logic legal_op, dw, misal;
        logic [63:0] old, nv;
        int target;
        legal_op = (f5 inside {5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                               5'b10000, 5'b10100, 5'b11000, 5'b11100});
        dw = (sz == 3'b011);
        e.idx = int'(addr[6:3]);
        e.mem_exp = mem[e.idx];
        e.addr = addr;
        e.rd_we = 1'b0; e.rd_data = '0; e.reads = 0; e.writes = 0;
        misal = dw ? (addr[2:0] != 0) : (addr[1:0] != 0);
        if (!legal_op || !(sz inside {3'b010, 3'b011})) e.flags = 3'b010;
        else if (misal) e.flags = 3'b001;
        else begin
            e.reads = 1;
            if (addr[11:8] == 4'hF) e.flags = 3'b100;
            else begin
                e.writes = 1;
                old = dw ? mem[e.idx] : (addr[2] ? {32'b0, mem[e.idx][63:32]} : {32'b0, mem[e.idx][31:0]});
                nv = ref_result(f5, dw, old, opd);
                if (addr[11:8] == 4'hE) e.flags = 3'b100;
                else begin
                    e.flags = 3'b000;
                    e.rd_we = 1'b1;
                    e.rd_data = dw ? old : sx32(old[31:0]);
                    if (dw) e.mem_exp = nv;
                    else if (addr[2]) e.mem_exp[63:32] = nv[31:0];
                    else e.mem_exp[31:0] = nv[31:0];
                end
            end
        end
        sb_q.push_back(e);
        tag_q.push_back(tag);
        target = done_seen + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_funct5 = f5; req_size = sz; req_addr = addr; req_operand = opd;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_seen < target) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done_valid) begin
            exp_t e;
            string t;
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual=unexpected done expected=none");
            end else begin
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check({t, " rd_we"}, 64'(done_rd_we), 64'(e.rd_we));
                if (e.rd_we) check({t, " rd_data"}, done_rd_data, e.rd_data);
                check({t, " flags"}, 64'({done_fault, done_illegal, done_misaligned}), 64'(e.flags));
                if (e.flags != 3'b000 && e.flags != 3'b010)
                    check({t, " fault_addr"}, done_fault_addr, e.addr);
                check({t, " reads"}, 64'(n_reads), 64'(e.reads));
                check({t, " writes"}, 64'(n_writes), 64'(e.writes));
                if (e.writes == 1) check({t, " R10 write addr"}, wr_addr_seen, rd_addr_seen);
                check({t, " memory"}, mem[e.idx], e.mem_exp);
            end
            n_reads = 0; n_writes = 0;
            done_seen++;
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_0000_0101);
        mem[1] = 64'h8000_0000_FFFF_FFF0;
        mem[2] = 64'hFFFF_FFFF_FFFF_FF00;
        mem[3] = 64'h7FFF_FFF0_8000_0005;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset ready", 64'(req_ready), 64'd1);
        check("R11 reset mem_req", 64'(mem_req), 64'd0);
        check("R11 reset done", 64'(done_valid), 64'd0);

        do_amo("R2 swap dword",  5'b00001, 3'b011, 64'h000, 64'hA5A5_0000_1234_5678);
        do_amo("R2 add dword",   5'b00000, 3'b011, 64'h000, 64'h0000_0001_0000_0001);
        do_amo("R2 xor word",    5'b00100, 3'b010, 64'h04C, 64'h0F0F_F0F0);
        do_amo("R2 and word",    5'b01100, 3'b010, 64'h028, 64'hFFFF_0FF0);
        do_amo("R2 or word",     5'b01000, 3'b010, 64'h030, 64'h0000_0003);
        do_amo("R5 add word carry", 5'b00000, 3'b010, 64'h008, 64'h0000_0020);
        do_amo("R6 word signext", 5'b00100, 3'b010, 64'h00C, 64'h0);
        do_amo("R3 min dword",   5'b10000, 3'b011, 64'h010, 64'h0000_0000_0000_0005);
        do_amo("R3 max dword",   5'b10100, 3'b011, 64'h010, 64'h0000_0000_0000_0005);
        do_amo("R3 min word",    5'b10000, 3'b010, 64'h018, 64'h0000_0001);
        do_amo("R3 max word",    5'b10100, 3'b010, 64'h01C, 64'hFFFF_FFFF);
        do_amo("R4 minu word",   5'b11000, 3'b010, 64'h008, 64'h0000_0010);
        do_amo("R4 maxu word",   5'b11100, 3'b010, 64'h01C, 64'h8000_0001);
        do_amo("R4 maxu dword",  5'b11100, 3'b011, 64'h020, 64'h8000_0000_0000_0000);
        do_amo("R4 minu dword",  5'b11000, 3'b011, 64'h028, 64'hFFFF_FFFF_FFFF_FFFF);
        do_amo("R1 bad funct5",  5'b00010, 3'b010, 64'h040, 64'h1);
        do_amo("R1 bad size",    5'b00000, 3'b000, 64'h040, 64'h1);
        do_amo("R1 size 100",    5'b00001, 3'b100, 64'h040, 64'h1);
        do_amo("R7 word misal",  5'b00000, 3'b010, 64'h042, 64'h1);
        do_amo("R7 dword misal", 5'b00001, 3'b011, 64'h044, 64'h1);
        do_amo("R8 read fault",  5'b00000, 3'b011, 64'hF08, 64'h1);
        do_amo("R9 write fault", 5'b00001, 3'b010, 64'hE10, 64'h1);
        do_amo("R10 after faults", 5'b00000, 3'b011, 64'h038, 64'h7);

        check("R10 lock during access", 64'(lock_bad), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule